// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Controller

This block collects single-cycle event pulses from a network controller into sticky status bits and drives one combined interrupt request. Each event source owns one bit position. The status register is read through a small register bus. A read returns the latched bits and clears them in the same cycle. An event that arrives in the cycle of the clearing read is kept for the next read, so no event is lost.

Interrupt gating uses an inverted mask: a mask bit at 1 blocks its source. Software never writes the mask directly. A write of ones to the enable register clears mask bits, and a write of ones to the disable register sets them. The mask itself can be read back. One source, the link-change bit, does not come from a pulse input. It comes from a level input that is synchronised through two flops, and either edge of that input sets the bit.

Bit positions (NUM_SRC = 14): 0 management transfer done, 1 receive done, 2 receive descriptor already used, 3 transmit descriptor already used, 4 transmit underrun, 5 retry limit hit, 6 transmit buffers ran out mid-frame, 7 transmit done, 8 reserved, 9 link change, 10 receive overrun, 11 bus error response, 12 pause frame seen, 13 pause timer expired.

Register selects on `bus_addr`: 0 status (read), 1 enable (write), 2 disable (write), 3 mask (read).

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset all status bits are 0, the mask reads 0x3EFF (every implemented bit masked, bit 8 zero), irq_o is 0 and bus_rdata is 0.
- R2: A 1 on evt_i[n] in a cycle sets status bit n at that rising edge, and the bit stays set until the status register is read.
- R3: A read of address 0 returns the status bits in bus_rdata[13:0] and clears every bit, so an immediate second read returns 0.
- R4: An event pulse in the same cycle as a status read is absent from that read's data and is returned by the next status read.
- R5: Writing address 1 clears each mask bit whose bus_wdata bit is 1. Zero bits leave the mask unchanged.
- R6: Writing address 2 sets each mask bit whose bus_wdata bit is 1. Zero bits leave the mask unchanged.
- R7: irq_o is a register loaded each cycle with the OR of (status AND NOT mask). It rises one edge after an unmasked status bit appears, stays 0 for masked bits, and falls one edge after the status read or after the masking write.
- R8: Bit 8 reads 0 in both the status and the mask registers. evt_i[8] and evt_i[9] have no effect, and writes to bit 8 of either mask-control register have no effect.
- R9: Each change of link_i, rising or falling, sets status bit 9. The bit is visible after the third rising edge that follows the change. A steady link_i sets nothing.
- R10: Writes to address 0 or 3 change no state. Reads of address 1 or 2 return 0.
- R11: bus_rdata is loaded at the rising edge that samples a read and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 14 | One-cycle event pulses, one per status bit |
| link_i | input | 1 | Asynchronous link level |
| bus_valid | input | 1 | Bus access strobe for this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data, mask-control bits in [13:0] |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that each bus access lasts exactly one cycle with bus_valid high, so that a clear or a mask write affects only the next edge. They also assume that link_i is low while reset is applied, because the synchroniser resets to 0 and a high level at release would count as an edge. The stimulus drives every input on the falling edge. It raises bus_valid for a single cycle per access, releases reset with link_i low, and changes link_i only after reset is released.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      SEL_STATUS  = 2'd0,
      SEL_ENABLE  = 2'd1,
      SEL_DISABLE = 2'd2,
      SEL_MASK    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_link_edge.sv
module irq_link_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_i,
   output logic edge_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("irq_link_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], link_i};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign edge_o = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
   parameter int unsigned      NUM_SRC   = 14,
   parameter logic [NUM_SRC-1:0] RSVD_MASK = 'h100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic               rd_clr_i,
   output logic [NUM_SRC-1:0] status_o
);
   localparam logic [NUM_SRC-1:0] LIVE = ~RSVD_MASK;

   genvar b;
   generate
      for (b = 0; b < NUM_SRC; b++) begin : g_bit
         if (RSVD_MASK[b]) begin : g_rsvd
            assign status_o[b] = 1'b0;
         end else begin : g_live
            logic st_q;
            always_ff @(posedge clk) begin
               if (!rst_n)        st_q <= 1'b0;
               else if (rd_clr_i) st_q <= set_i[b];
               else               st_q <= st_q | set_i[b];
            end
            assign status_o[b] = st_q;
         end
      end
   endgenerate

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & LIVE) != '0) |=> ((status_o & $past(set_i & LIVE)) == $past(set_i & LIVE))); // R2
   AST_NO_SPONTANEOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R2
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr_i |=> ((status_o & ~$past(set_i)) == '0)); // R3
   AST_RACE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && ((set_i & LIVE) != '0)) |=> ((status_o & $past(set_i & LIVE)) != '0)); // R4
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned      NUM_SRC   = 14,
   parameter logic [NUM_SRC-1:0] RSVD_MASK = 'h100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_we_i,
   input  logic               dis_we_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   output logic [NUM_SRC-1:0] mask_o
);
   localparam logic [NUM_SRC-1:0] LIVE = ~RSVD_MASK;

   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] set_bits;
   logic [NUM_SRC-1:0] clr_bits;

   always_comb begin
      set_bits = dis_we_i ? (wdata_i & LIVE) : '0;
      clr_bits = en_we_i  ? wdata_i          : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= LIVE;
      else        mask_q <= (mask_q | set_bits) & ~clr_bits & LIVE;
   end

   assign mask_o = mask_q;

   AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      en_we_i |=> ((mask_o & $past(wdata_i)) == '0)); // R5
   AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      dis_we_i |=> ((mask_o & $past(wdata_i & LIVE)) == $past(wdata_i & LIVE))); // R6
   AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_we_i && !dis_we_i) |=> $stable(mask_o)); // R5
   AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & RSVD_MASK) == '0); // R8
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int unsigned        NUM_SRC   = 14,
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        LINK_BIT  = 9,
   parameter logic [NUM_SRC-1:0] RSVD_MASK = 'h100,
   parameter bit                 IRQ_REG   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0]       evt_i,
   input  logic                     link_i,
   input  logic                     bus_valid,
   input  logic                     bus_write,
   input  logic [irq_pkg::SEL_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     irq_o
);
   import irq_pkg::*;

   localparam logic [NUM_SRC-1:0] LINK_ONEHOT = NUM_SRC'(1) << LINK_BIT;
   localparam logic [NUM_SRC-1:0] PULSE_LIVE  = ~(RSVD_MASK | LINK_ONEHOT);

   generate
      if (LINK_BIT >= NUM_SRC) begin : g_bad_link
         $error("irq_status_ctrl: LINK_BIT outside the status vector");
      end
      if (DATA_W < NUM_SRC) begin : g_bad_width
         $error("irq_status_ctrl: DATA_W narrower than NUM_SRC");
      end
      if (RSVD_MASK[LINK_BIT]) begin : g_bad_rsvd
         $error("irq_status_ctrl: link bit may not be reserved");
      end
   endgenerate

   reg_sel_e           sel;
   logic               rd_any, wr_any;
   logic               rd_status, en_we, dis_we;
   logic               link_edge;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] pending;
   logic [DATA_W-1:0]  rdata_q;
   logic               unused_wdata;

   assign sel          = reg_sel_e'(bus_addr);
   assign rd_any       = bus_valid && !bus_write;
   assign wr_any       = bus_valid &&  bus_write;
   assign rd_status    = rd_any && (sel == SEL_STATUS);
   assign en_we        = wr_any && (sel == SEL_ENABLE);
   assign dis_we       = wr_any && (sel == SEL_DISABLE);
   assign unused_wdata = ^bus_wdata;

   irq_link_edge #(.SYNC_STAGES(2)) u_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .link_i (link_i),
      .edge_o (link_edge)
   );

   assign set_vec = (evt_i & PULSE_LIVE) | (link_edge ? LINK_ONEHOT : '0);

   irq_status_bank #(.NUM_SRC(NUM_SRC), .RSVD_MASK(RSVD_MASK)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec),
      .rd_clr_i (rd_status),
      .status_o (status)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC), .RSVD_MASK(RSVD_MASK)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_we_i  (en_we),
      .dis_we_i (dis_we),
      .wdata_i  (bus_wdata[NUM_SRC-1:0]),
      .mask_o   (mask)
   );

   assign pending = status & ~mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (rd_any) begin
         case (sel)
            SEL_STATUS: rdata_q <= DATA_W'(status);
            SEL_MASK:   rdata_q <= DATA_W'(mask);
            default:    rdata_q <= '0;
         endcase
      end
   end
   assign bus_rdata = rdata_q;

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |pending;
         end
         assign irq_o = irq_q;

         AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o) |-> $past(|(status & ~mask))); // R7
         AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            ((status & ~mask) == '0) |=> !irq_o); // R7
      end else begin : g_irq_comb
         assign irq_o = |pending;
      end
   endgenerate

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_any |=> $stable(bus_rdata)); // R11
   AST_RDATA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[NUM_SRC-1:0] & RSVD_MASK) == '0); // R8
   AST_IDLE_REG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_any && (sel == SEL_ENABLE || sel == SEL_DISABLE)) |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] evt_i = '0;
   logic        link_i = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_status_ctrl uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .link_i(link_i),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_valid = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
   endtask

   task automatic pulse(input logic [13:0] b);
      evt_i = b;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 irq after reset", 32'(irq_o), 0);
      chk("R1 rdata after reset", bus_rdata, 0);
      rd(2'd0, d); chk("R1 status after reset", d, 0);
      rd(2'd3, d); chk("R1 mask after reset", d, 32'h3EFF);
   endtask

   task automatic t_sticky;
      logic [31:0] d;
      pulse(14'h0001);
      repeat (3) @(negedge clk);
      chk("R7 masked source keeps irq low", 32'(irq_o), 0);
      rd(2'd0, d); chk("R2 sticky bit 0", d, 32'h0001);
      rd(2'd0, d); chk("R3 second read cleared", d, 0);
      pulse(14'h2400);
      rd(2'd0, d); chk("R2 bits 10 and 13", d, 32'h2400);
      rd(2'd0, d); chk("R3 cleared again", d, 0);
   endtask

   task automatic t_mask_ops;
      logic [31:0] d;
      wr(2'd1, 32'h0005); rd(2'd3, d); chk("R5 enable clears bits", d, 32'h3EFA);
      wr(2'd1, 32'h0000); rd(2'd3, d); chk("R5 zero enable no effect", d, 32'h3EFA);
      wr(2'd2, 32'h0004); rd(2'd3, d); chk("R6 disable sets bit", d, 32'h3EFE);
      wr(2'd2, 32'h0000); rd(2'd3, d); chk("R6 zero disable no effect", d, 32'h3EFE);
      wr(2'd1, 32'h0100); rd(2'd3, d); chk("R8 enable of bit 8 ignored", d, 32'h3EFE);
      wr(2'd2, 32'h0101); rd(2'd3, d); chk("R8 disable of bit 8 ignored", d, 32'h3EFF);
      wr(2'd1, 32'h0001); rd(2'd3, d); chk("R5 re-enable bit 0", d, 32'h3EFE);
   endtask

   task automatic t_irq;
      logic [31:0] d;
      pulse(14'h0001);
      chk("R7 irq not yet", 32'(irq_o), 0);
      @(negedge clk);
      chk("R7 irq rises", 32'(irq_o), 1);
      pulse(14'h0004);
      chk("R7 irq held", 32'(irq_o), 1);
      rd(2'd0, d); chk("R3 read two bits", d, 32'h0005);
      chk("R7 irq one edge after read", 32'(irq_o), 1);
      @(negedge clk);
      chk("R7 irq falls after read", 32'(irq_o), 0);
      pulse(14'h0010);
      @(negedge clk);
      chk("R7 masked bit 4 no irq", 32'(irq_o), 0);
      wr(2'd1, 32'h0010);
      chk("R7 irq lags enable", 32'(irq_o), 0);
      @(negedge clk);
      chk("R7 irq after enable", 32'(irq_o), 1);
      wr(2'd2, 32'h0010);
      chk("R7 irq lags disable", 32'(irq_o), 1);
      @(negedge clk);
      chk("R7 irq falls after masking", 32'(irq_o), 0);
      rd(2'd0, d); chk("R2 masked bit still latched", d, 32'h0010);
   endtask

   task automatic t_same_cycle;
      logic [31:0] d;
      evt_i = 14'h0080;
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 2'd0;
      @(negedge clk);
      evt_i = '0; bus_valid = 1'b0;
      chk("R4 racing event not in read", bus_rdata, 0);
      rd(2'd0, d); chk("R4 racing event kept", d, 32'h0080);
   endtask

   task automatic t_reserved;
      logic [31:0] d;
      pulse(14'h0300);
      @(negedge clk);
      rd(2'd0, d); chk("R8 evt bits 8 and 9 ignored", d, 0);
   endtask

   task automatic t_bus_misc;
      logic [31:0] d;
      pulse(14'h0002);
      wr(2'd0, 32'h3FFF);
      wr(2'd3, 32'h0000);
      rd(2'd3, d); chk("R10 write to mask address ignored", d, 32'h3EFE);
      rd(2'd0, d); chk("R10 write to status address ignored", d, 32'h0002);
      rd(2'd1, d); chk("R10 enable reads zero", d, 0);
      rd(2'd3, d);
      pulse(14'h0008);
      repeat (3) @(negedge clk);
      chk("R11 rdata holds while idle", bus_rdata, 32'h3EFE);
      rd(2'd2, d); chk("R10 disable reads zero", d, 0);
      rd(2'd0, d); chk("R11 status returned on read", d, 32'h0008);
   endtask

   task automatic t_link;
      logic [31:0] d;
      link_i = 1'b1;
      repeat (2) @(negedge clk);
      rd(2'd0, d); chk("R9 not visible before third edge", d, 0);
      rd(2'd0, d); chk("R9 rising link sets bit 9", d, 32'h0200);
      link_i = 1'b0;
      repeat (4) @(negedge clk);
      rd(2'd0, d); chk("R9 falling link sets bit 9", d, 32'h0200);
      repeat (5) @(negedge clk);
      rd(2'd0, d); chk("R9 steady link sets nothing", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sticky();
      t_mask_ops();
      t_irq();
      t_same_cycle();
      t_reserved();
      t_bus_misc();
      t_link();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule